// File: doc/BRIEF.md
# Paged outbound bus address extender

This block gives one processor node a page register that widens its 20-bit window address into a 32-bit address on a wider system bus. Software writes the page register with the upper 12 address bits and with the control fields for the outbound cycles: a function code for the access type, a transfer-size code and two low address lines used for byte-lane correction. Each later access into the outbound window combines the latched upper bits with the 20 low processor address bits. The block hands the result, together with the control fields, to a bus bridge as a one-cycle start pulse.

The page register sits at local address 0x016D_0000. The outbound window is the 1 Mbyte region starting at 0x0170_0000. Every read or write of the page register first has to win a global shared bus. The block raises a request and holds back the processor's ready until the grant is present and the shared bus is no longer busy. Outbound window accesses do not use this handshake. Their completion belongs to the bridge.

Top module: `page_addr_extender`

## Requirements
- R1: A completed page-register write stores write-data bits 19..8 as upper address bits 31..20 (data bit 19 to address bit 31, and so on downward) and stores write-data bits 7..0 as the control byte.
- R2: A read or write strobe whose address bits 31..20 equal 0x017 is an outbound window access. In the next cycle `out_start` is high for exactly one cycle and `out_addr` is {stored upper bits, strobe address bits 19..0}. For example, after page data 0x0008_0000 an access at window offset 0 gives 0x8000_0000.
- R3: Alongside each `out_start`, `out_fc` carries control bits 6..4, `out_size` carries bits 3..2 and `out_lane` carries bits 1..0 of the stored page value.
- R4: A page-register read returns zeros in bits 31..20, the stored upper bits in bits 19..8 and the stored control byte, including the plain storage bit 7, in bits 7..0. Write-data bits 31..20 are ignored.
- R5: A strobe at exactly 0x016D_0000 raises `sb_req` in the next cycle. `sb_req` stays high through every cycle in which `lcl_ready` has not yet been asserted.
- R6: `lcl_ready` goes high for exactly one cycle, in the cycle after the first clock edge at which `sb_req`, `sb_gnt` and not `sb_busy` are all true. That edge is also when a write takes effect. In the cycle after `lcl_ready`, both `sb_req` and `lcl_ready` are low.
- R7: If a page-register write takes effect at the same edge at which a window access is sampled, that outbound cycle uses the previous page value. The next window access uses the new one.
- R8: A strobe that hits neither the page register nor the window raises neither `sb_req` nor `out_start` and leaves the page value unchanged.
- R9: After reset, `sb_req`, `lcl_ready` and `out_start` are low. The page value itself has no reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_addr | input | 32 | Local address, valid with a strobe |
| lcl_wdata | input | 32 | Local write data, valid with a write strobe |
| lcl_wr | input | 1 | One-cycle write strobe |
| lcl_rd | input | 1 | One-cycle read strobe |
| lcl_rdata | output | 32 | Page-register read data, valid with lcl_ready |
| lcl_ready | output | 1 | One-cycle completion of a page-register access |
| sb_req | output | 1 | Global shared bus request |
| sb_gnt | input | 1 | Global shared bus grant |
| sb_busy | input | 1 | Shared bus operation still in progress |
| out_start | output | 1 | One-cycle start of an outbound cycle |
| out_addr | output | 32 | Outbound 32-bit address |
| out_fc | output | 3 | Outbound function code |
| out_size | output | 2 | Outbound transfer-size code |
| out_lane | output | 2 | Outbound low address lines |

## Verification
The assertions rely on one input rule: only one page-register access is open at a time. The processor issues no new page-register strobe between its strobe and the matching `lcl_ready`, and it never raises read and write together. The bench keeps to this rule because every page-register access runs inside one task that returns only after the release cycle. Window strobes may still overlap a pending register access, and one directed case places such a strobe on the commit edge. Before any read, the bench writes the page register, so no check depends on the undefined power-up contents.

// File: rtl/pae_pkg.sv
package pae_pkg;
  typedef enum logic [1:0] {
    SB_IDLE = 2'd0,
    SB_WAIT = 2'd1,
    SB_DONE = 2'd2
  } sb_state_t;
endpackage

// File: rtl/pae_decode.sv
module pae_decode #(
  parameter int          ADDR_W    = 32,
  parameter int          OFFS_W    = 20,
  parameter logic [31:0] PAGE_ADDR = 32'h016D_0000,
  parameter logic [31:0] WIN_BASE  = 32'h0170_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_page,
  output logic              hit_win
);
  localparam int HI_W = ADDR_W - OFFS_W;
  localparam logic [HI_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFFS_W];

  logic unused_base;
  assign unused_base = ^WIN_BASE[OFFS_W-1:0];

  always_comb begin
    hit_page = (addr == PAGE_ADDR[ADDR_W-1:0]);
    hit_win  = (addr[ADDR_W-1:OFFS_W] == WIN_TAG);
  end
endmodule

// File: rtl/pae_page_reg.sv
module pae_page_reg #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 20,
  parameter int HI_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [HI_W-1:0]   page_hi,
  output logic [OFFS_W-HI_W-1:0] page_lo,
  output logic [DATA_W-1:0] rd_word
);
  localparam int LO_W = OFFS_W - HI_W;

  logic unused_wd;
  assign unused_wd = ^wdata[DATA_W-1:OFFS_W];

  // Contents deliberately have no reset value.
  always_ff @(posedge clk) begin
    if (we) begin
      page_hi <= wdata[OFFS_W-1:LO_W];
      page_lo <= wdata[LO_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[OFFS_W-1:0] = {page_hi, page_lo};
  end

  // R1: without a commit the stored page never moves
  a_r1_page_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({page_hi, page_lo}));
endmodule

// File: rtl/pae_sb_fsm.sv
module pae_sb_fsm #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_wr,
  input  logic              go_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              sb_gnt,
  input  logic              sb_busy,
  output logic              sb_req,
  output logic              commit_we,
  output logic [DATA_W-1:0] commit_data,
  output logic              ready,
  output logic [DATA_W-1:0] rdata
);
  import pae_pkg::*;

  sb_state_t state;
  logic      pend_wr;
  logic      won;

  assign won       = (state == SB_WAIT) && sb_gnt && !sb_busy;
  assign commit_we = won && pend_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SB_IDLE;
      sb_req  <= 1'b0;
      ready   <= 1'b0;
      pend_wr <= 1'b0;
    end else begin
      case (state)
        SB_IDLE: if (go_wr || go_rd) begin
          state   <= SB_WAIT;
          sb_req  <= 1'b1;
          pend_wr <= go_wr;
        end
        SB_WAIT: if (won) begin
          state <= SB_DONE;
          ready <= 1'b1;
        end
        default: begin
          state  <= SB_IDLE;
          ready  <= 1'b0;
          sb_req <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == SB_IDLE && go_wr) commit_data <= wdata;
    if (won) rdata <= rd_word;
  end

  // R5: request held until ready
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (sb_req && !ready) |=> sb_req);
  // R6: ready only after a free grant
  a_r6_ready_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(sb_req && sb_gnt && !sb_busy));
  // R6: single-cycle ready, request released after it
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    ready |=> (!ready && !sb_req));
  // R4: reserved read bits are zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ready |-> (rdata[DATA_W-1:OFFS_W] == '0));
endmodule

// File: rtl/pae_outbound.sv
module pae_outbound #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 20,
  parameter int HI_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic [OFFS_W-1:0]      offset,
  input  logic [HI_W-1:0]        page_hi,
  input  logic [OFFS_W-HI_W-1:0] page_lo,
  output logic                   out_start,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [2:0]             out_fc,
  output logic [1:0]             out_size,
  output logic [1:0]             out_lane
);
  always_ff @(posedge clk) begin
    if (rst) out_start <= 1'b0;
    else     out_start <= go;
  end

  always_ff @(posedge clk) begin
    if (go) begin
      out_addr <= {page_hi, offset};
      out_fc   <= page_lo[6:4];
      out_size <= page_lo[3:2];
      out_lane <= page_lo[1:0];
    end
  end

  // R2: start is a single-cycle pulse per strobe
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    (out_start && !$past(go)) |-> 1'b0);
  // R2: offset taken from the strobed address
  a_r2_offset: assert property (@(posedge clk) disable iff (rst)
    go |=> (out_addr[OFFS_W-1:0] == $past(offset)));
endmodule

// File: rtl/page_addr_extender.sv
module page_addr_extender #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          OFFS_W    = 20,
  parameter logic [31:0] PAGE_ADDR = 32'h016D_0000,
  parameter logic [31:0] WIN_BASE  = 32'h0170_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic [DATA_W-1:0] lcl_wdata,
  input  logic              lcl_wr,
  input  logic              lcl_rd,
  output logic [DATA_W-1:0] lcl_rdata,
  output logic              lcl_ready,
  output logic              sb_req,
  input  logic              sb_gnt,
  input  logic              sb_busy,
  output logic              out_start,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_fc,
  output logic [1:0]        out_size,
  output logic [1:0]        out_lane
);
  localparam int HI_W = ADDR_W - OFFS_W;
  localparam int LO_W = OFFS_W - HI_W;

  logic              hit_page, hit_win;
  logic              commit_we;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] rd_word;
  logic [HI_W-1:0]   page_hi;
  logic [LO_W-1:0]   page_lo;
  logic              win_go;

  pae_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
               .PAGE_ADDR(PAGE_ADDR), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(lcl_addr), .hit_page(hit_page), .hit_win(hit_win));

  pae_sb_fsm #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_fsm (
    .clk(clk), .rst(rst),
    .go_wr(lcl_wr && hit_page), .go_rd(lcl_rd && hit_page),
    .wdata(lcl_wdata), .rd_word(rd_word),
    .sb_gnt(sb_gnt), .sb_busy(sb_busy), .sb_req(sb_req),
    .commit_we(commit_we), .commit_data(commit_data),
    .ready(lcl_ready), .rdata(lcl_rdata));

  pae_page_reg #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .HI_W(HI_W)) u_page (
    .clk(clk), .rst(rst), .we(commit_we), .wdata(commit_data),
    .page_hi(page_hi), .page_lo(page_lo), .rd_word(rd_word));

  assign win_go = (lcl_wr || lcl_rd) && hit_win;

  pae_outbound #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .HI_W(HI_W)) u_out (
    .clk(clk), .rst(rst), .go(win_go), .offset(lcl_addr[OFFS_W-1:0]),
    .page_hi(page_hi), .page_lo(page_lo),
    .out_start(out_start), .out_addr(out_addr),
    .out_fc(out_fc), .out_size(out_size), .out_lane(out_lane));

  // R8: no request without a page-register strobe
  a_r8_no_stray_req: assert property (@(posedge clk) disable iff (rst)
    $rose(sb_req) |-> $past((lcl_wr || lcl_rd) && hit_page));
endmodule

// File: tb/tb_page_addr_extender.sv
`timescale 1ns/1ps
module tb_page_addr_extender;
  localparam logic [31:0] PG  = 32'h016D_0000;
  localparam logic [31:0] WIN = 32'h0170_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lcl_addr, lcl_wdata, lcl_rdata, out_addr;
  logic        lcl_wr, lcl_rd, lcl_ready, sb_req, sb_gnt, sb_busy, out_start;
  logic [2:0]  out_fc;
  logic [1:0]  out_size, out_lane;

  int n_chk = 0, n_bad = 0;
  logic [11:0] m_hi;
  logic [7:0]  m_lo;
  bit done = 0;

  always #2 clk = ~clk;

  page_addr_extender dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    return {12'h000, m_hi, m_lo};
  endfunction

  // page-register access; overlap launches a window strobe on the commit edge
  task automatic reg_acc(input bit wr, input logic [31:0] d, input int wait_n,
                         input bit overlap, input logic [19:0] ov_off);
    logic [31:0] ov_exp;
    @(negedge clk);
    lcl_addr = PG; lcl_wdata = d; lcl_wr = wr; lcl_rd = !wr;
    @(negedge clk);
    lcl_wr = 0; lcl_rd = 0;
    chk(sb_req === 1'b1, "R5 req raised", {31'b0, sb_req}, 1);
    for (int i = 0; i < wait_n; i++) begin
      if (i % 2 == 0) begin sb_gnt = 0; sb_busy = 0; end
      else begin sb_gnt = 1; sb_busy = 1; end
      @(negedge clk);
      chk(sb_req === 1'b1 && lcl_ready === 1'b0, "R5 held while blocked",
          {30'b0, sb_req, lcl_ready}, 32'h2);
    end
    sb_gnt = 1; sb_busy = 0;
    ov_exp = {m_hi, ov_off};
    if (overlap) begin lcl_addr = WIN | {12'h0, ov_off}; lcl_rd = 1; end
    @(negedge clk);
    lcl_rd = 0; sb_gnt = 0;
    chk(lcl_ready === 1'b1, "R6 ready after free grant", {31'b0, lcl_ready}, 1);
    if (!wr) chk(lcl_rdata === exp_rd(), "R4 readback", lcl_rdata, exp_rd());
    if (overlap) chk(out_start === 1'b1 && out_addr === ov_exp, "R7 old page on commit edge",
                     out_addr, ov_exp);
    if (wr) begin m_hi = d[19:8]; m_lo = d[7:0]; end
    @(negedge clk);
    chk(lcl_ready === 1'b0 && sb_req === 1'b0, "R6 release", {30'b0, sb_req, lcl_ready}, 0);
  endtask

  task automatic win_acc(input logic [19:0] off, input bit wr);
    logic [31:0] ea;
    ea = {m_hi, off};
    @(negedge clk);
    lcl_addr = WIN | {12'h0, off}; lcl_wr = wr; lcl_rd = !wr;
    @(negedge clk);
    lcl_wr = 0; lcl_rd = 0;
    chk(out_start === 1'b1 && out_addr === ea, "R2 outbound address", out_addr, ea);
    chk({out_fc, out_size, out_lane} === m_lo[6:0], "R3 control fields",
        {25'b0, out_fc, out_size, out_lane}, {25'b0, m_lo[6:0]});
    @(negedge clk);
    chk(out_start === 1'b0, "R2 single pulse", {31'b0, out_start}, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'd4242);
    rst = 1; lcl_addr = 0; lcl_wdata = 0; lcl_wr = 0; lcl_rd = 0; sb_gnt = 0; sb_busy = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sb_req === 0 && lcl_ready === 0 && out_start === 0, "R9 reset state",
        {29'b0, sb_req, lcl_ready, out_start}, 0);

    // R1/R2 directed example
    reg_acc(1, 32'h0008_0000, 0, 0, 0);
    win_acc(20'h0, 0);
    chk(out_addr === 32'h8000_0000, "R1 example address", out_addr, 32'h8000_0000);

    // R4 reserved write bits ignored, bit 7 stored
    reg_acc(1, 32'hFFF5_A3DB, 2, 0, 0);
    reg_acc(0, 0, 1, 0, 0);
    win_acc(20'hFFFFF, 1);

    // R8 unrelated address
    @(negedge clk); lcl_addr = 32'h016D_0004; lcl_wdata = 32'h0; lcl_wr = 1;
    @(negedge clk); lcl_wr = 0;
    chk(sb_req === 0 && out_start === 0, "R8 stray strobe ignored",
        {30'b0, sb_req, out_start}, 0);
    @(negedge clk);
    chk(sb_req === 0, "R8 no late request", {31'b0, sb_req}, 0);
    reg_acc(0, 0, 0, 0, 0);

    // R7 write commit overlapping window strobe
    reg_acc(1, 32'h0001_2374, 3, 1, 20'h0ABCD);
    win_acc(20'h0ABCD, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      reg_acc(1, $urandom, $urandom_range(0, 4), 0, 0);
      reg_acc(0, 0, $urandom_range(0, 3), 0, 0);
      win_acc(20'($urandom), 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule